// File: doc/BRIEF.md
# Multi-bank flash command dispatcher

This block sits between a host and a set of per-bank flash operation sequencers. Each bank owns a group of eleven operand registers: an opcode, an option word, a buffer address, a transfer count, source column and row (row split into low and high words), destination column and row (also split), and a command tag. The host fills a bank's group through a single register write port that is indexed by bank and register number. It then pulses a start strobe that names the bank.

On start, the opcode of the named bank is decoded into the entry state of that bank's sequencer. A program goes first to a buffer-to-flash data phase when its buffer address is nonzero, and straight to command issue when it is zero. Read, copyback and erase each have their own entry state. Opcodes that are defined but not supported, and opcodes outside the defined set, raise separate one-cycle error pulses and leave the bank idle. The pin-level sequencing and the data mover are outside the block. They appear only as per-bank transfer-done and operation-done pulses. The operand registers can be read back combinationally by bank and register number, so that the downstream sequencers can fetch their operands.

Top module: `flash_cmd_dispatch`

## Requirements
- R1: After reset every bank is idle (state code 0, busy low), every transfer-done flag is 1, all three error outputs are 0, and every operand register reads 0.
- R2: A write to an idle bank stores wr_data in register wr_sel of bank wr_bank: 0 opcode, 1 option, 2 buffer address, 3 count, 4 column, 5 row low, 6 row high, 7 destination column, 8 destination row low, 9 destination row high, 10 tag. Reading with rd_bank/rd_sel returns it in the same cycle. A write or read with wr_sel/rd_sel of 11 or more stores nothing and reads 0.
- R3: A write to a busy bank leaves that bank's registers unchanged, and err_coll is high for exactly the next cycle.
- R4: A start to an idle bank with a supported opcode sets that bank's state on the next clock edge and raises its busy output. The opcode is taken from the low 6 bits of register 0, and the higher bits are ignored.
- R5: Opcode 0x01 (program) with a nonzero buffer address enters state 1 (data transfer) and clears that bank's transfer-done flag.
- R6: Opcode 0x01 with a buffer address of zero enters state 2 (write command) and leaves the transfer-done flag unchanged.
- R7: Opcode 0x02 (read) enters state 3, 0x03 (copyback) enters state 4, and 0x04 (erase) enters state 5.
- R8: Opcodes 0x05 through 0x10 are unsupported. Starting one pulses err_unsup for one cycle and leaves the bank idle.
- R9: Opcode 0x00 and opcodes 0x11 through 0x3F are invalid. Starting one pulses err_inval for one cycle and leaves the bank idle.
- R10: A transfer-done pulse for a bank in state 1 moves it to state 2 on the next edge and sets its transfer-done flag. In any other state the pulse has no effect.
- R11: An operation-done pulse for a busy bank returns it to idle on the next edge, and it takes priority over a transfer-done pulse in the same cycle. For an idle bank the pulse has no effect.
- R12: A start to a busy bank changes no state and pulses err_coll for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 2 | Bank targeted by the write |
| wr_sel | input | 4 | Register number within the bank |
| wr_data | input | 32 | Write data |
| start | input | 1 | Start strobe |
| start_bank | input | 2 | Bank to start |
| xfer_done | input | 4 | Per-bank data transfer completion pulse |
| op_done | input | 4 | Per-bank operation completion pulse |
| rd_bank | input | 2 | Bank for operand read-back |
| rd_sel | input | 4 | Register number for read-back |
| rd_data | output | 32 | Operand read-back data |
| bank_state | output | 12 | Three-bit state code per bank, bank 0 in the low bits |
| bank_busy | output | 4 | Per-bank busy indication |
| xfer_flag | output | 4 | Per-bank transfer-done flag |
| err_unsup | output | 1 | One-cycle pulse for an unsupported opcode |
| err_inval | output | 1 | One-cycle pulse for an invalid opcode |
| err_coll | output | 1 | One-cycle pulse for a write or start aimed at a busy bank |

## Verification
A wrong entry decode shows up on bank_state at the edge right after the start strobe. A bank that never leaves a state shows as busy one edge after its operation-done pulse, when it should already be idle. A register that is corrupted or written while its bank is locked appears on rd_data as soon as that register is read back. It also surfaces indirectly at the next start, as a wrong entry state or a wrong choice between the transfer and command paths. Mis-sorted opcodes show as the wrong error pulse, or as a missing error pulse, exactly one cycle after the strobe. A reference model updated on every edge compares all of these outputs every cycle, so each fault is caught at the first cycle it becomes visible.

// File: rtl/fdisp_pkg.sv
package fdisp_pkg;
   localparam int OP_W  = 6;
   localparam int NREG  = 11;
   localparam int SEL_W = 4;

   localparam int R_OPC = 0;
   localparam int R_BUF = 2;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WXFER = 3'd1,
      ST_WCMD  = 3'd2,
      ST_RCMD  = 3'd3,
      ST_CBCMD = 3'd4,
      ST_ERCMD = 3'd5
   } bst_t;

   localparam logic [OP_W-1:0] OPC_PROG   = 6'h01;
   localparam logic [OP_W-1:0] OPC_READ   = 6'h02;
   localparam logic [OP_W-1:0] OPC_CPBK   = 6'h03;
   localparam logic [OP_W-1:0] OPC_ERASE  = 6'h04;
   localparam logic [OP_W-1:0] OPC_UNS_LO = 6'h05;
   localparam logic [OP_W-1:0] OPC_UNS_HI = 6'h10;
endpackage

// File: rtl/fd_opdec.sv
module fd_opdec
   import fdisp_pkg::*;
(
   input  logic [OP_W-1:0] opc,
   input  logic            buf_nz,
   output bst_t            entry,
   output logic            ok,
   output logic            unsup,
   output logic            inval
);
   always_comb begin
      entry = ST_IDLE;
      ok    = 1'b1;
      unsup = 1'b0;
      inval = 1'b0;
      case (opc)
         OPC_PROG:  entry = buf_nz ? ST_WXFER : ST_WCMD;
         OPC_READ:  entry = ST_RCMD;
         OPC_CPBK:  entry = ST_CBCMD;
         OPC_ERASE: entry = ST_ERCMD;
         default: begin
            ok = 1'b0;
            if (opc >= OPC_UNS_LO && opc <= OPC_UNS_HI) unsup = 1'b1;
            else                                        inval = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/fd_regs.sv
module fd_regs
   import fdisp_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [SEL_W-1:0]      sel,
   input  logic [REG_W-1:0]      wdata,
   input  logic                  lock,
   output logic [NREG*REG_W-1:0] q_flat
);
   logic [REG_W-1:0] rq [NREG];

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    rq[k] <= '0;
         else if (we && !lock && sel == SEL_W'(k))      rq[k] <= wdata;
      end
      assign q_flat[k*REG_W +: REG_W] = rq[k];
   end

   // R3: a locked bank keeps its operands
   p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && lock) |=> $stable(q_flat));
endmodule

// File: rtl/fd_bankseq.sv
module fd_bankseq
   import fdisp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  bst_t entry,
   input  logic xfer_done,
   input  logic op_done,
   output bst_t state,
   output logic xflag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         xflag <= 1'b1;
      end else if (load) begin
         state <= entry;
         if (entry == ST_WXFER) xflag <= 1'b0;
      end else if (state != ST_IDLE && op_done) begin
         state <= ST_IDLE;
      end else if (state == ST_WXFER && xfer_done) begin
         state <= ST_WCMD;
         xflag <= 1'b1;
      end
   end

   p_done_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && op_done) |=> state == ST_IDLE);
   p_xfer_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WXFER && xfer_done && !op_done) |=> (state == ST_WCMD && xflag));
   p_xfer_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && entry == ST_WXFER) |=> (state == ST_WXFER && !xflag));
endmodule

// File: rtl/flash_cmd_dispatch.sv
module flash_cmd_dispatch
   import fdisp_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int REG_W     = 32,
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int ST_W     = $bits(bst_t)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [BANK_W-1:0]         wr_bank,
   input  logic [SEL_W-1:0]          wr_sel,
   input  logic [REG_W-1:0]          wr_data,
   input  logic                      start,
   input  logic [BANK_W-1:0]         start_bank,
   input  logic [NUM_BANKS-1:0]      xfer_done,
   input  logic [NUM_BANKS-1:0]      op_done,
   input  logic [BANK_W-1:0]         rd_bank,
   input  logic [SEL_W-1:0]          rd_sel,
   output logic [REG_W-1:0]          rd_data,
   output logic [NUM_BANKS*ST_W-1:0] bank_state,
   output logic [NUM_BANKS-1:0]      bank_busy,
   output logic [NUM_BANKS-1:0]      xfer_flag,
   output logic                      err_unsup,
   output logic                      err_inval,
   output logic                      err_coll
);
   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (REG_W < OP_W) begin : g_bad_width
      $error("REG_W must hold an opcode");
   end

   logic [NREG*REG_W-1:0] bank_regs [NUM_BANKS];
   bst_t                  st        [NUM_BANKS];
   logic [NUM_BANKS-1:0]  load;

   logic       tgt_busy, buf_nz, dec_ok, dec_unsup, dec_inval, accept;
   bst_t       dec_entry;
   logic [OP_W-1:0] opc;

   assign tgt_busy = bank_busy[start_bank];
   assign opc      = bank_regs[start_bank][R_OPC*REG_W +: OP_W];
   assign buf_nz   = |bank_regs[start_bank][R_BUF*REG_W +: REG_W];
   assign accept   = start && !tgt_busy && dec_ok;

   fd_opdec u_dec (
      .opc   (opc),
      .buf_nz(buf_nz),
      .entry (dec_entry),
      .ok    (dec_ok),
      .unsup (dec_unsup),
      .inval (dec_inval)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign load[b] = accept && (start_bank == BANK_W'(b));

      fd_regs #(.REG_W(REG_W)) u_regs (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_en && (wr_bank == BANK_W'(b))),
         .sel   (wr_sel),
         .wdata (wr_data),
         .lock  (bank_busy[b]),
         .q_flat(bank_regs[b])
      );

      fd_bankseq u_seq (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load[b]),
         .entry    (dec_entry),
         .xfer_done(xfer_done[b]),
         .op_done  (op_done[b]),
         .state    (st[b]),
         .xflag    (xfer_flag[b])
      );

      assign bank_state[b*ST_W +: ST_W] = st[b];
      assign bank_busy[b]               = (st[b] != ST_IDLE);
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NREG; k++) begin
         if (rd_sel == SEL_W'(k)) rd_data = bank_regs[rd_bank][k*REG_W +: REG_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_unsup <= 1'b0;
         err_inval <= 1'b0;
         err_coll  <= 1'b0;
      end else begin
         err_unsup <= start && !tgt_busy && dec_unsup;
         err_inval <= start && !tgt_busy && dec_inval;
         err_coll  <= (start && tgt_busy) || (wr_en && bank_busy[wr_bank]);
      end
   end

   p_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_unsup && err_inval));
   p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> bank_busy[$past(start_bank)]);
   p_refuse_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !tgt_busy && !dec_ok) |=> !bank_busy[$past(start_bank)]);
   p_busy_start_coll_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (start && tgt_busy) |=> err_coll);
endmodule

// File: tb/sim_flash_cmd_dispatch.sv
module sim_flash_cmd_dispatch;
   localparam int CLK_P = 10;
   localparam int NB    = 4;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        wr_en = 0, start = 0;
   logic [1:0]  wr_bank = 0, start_bank = 0, rd_bank = 0;
   logic [3:0]  wr_sel = 0, rd_sel = 0;
   logic [31:0] wr_data = 0;
   logic [3:0]  xfer_done = 0, op_done = 0;
   logic [31:0] rd_data;
   logic [11:0] bank_state;
   logic [3:0]  bank_busy, xfer_flag;
   logic        err_unsup, err_inval, err_coll;

   flash_cmd_dispatch u0 (.*);

   always #(CLK_P/2) clk = ~clk;

   int          n_cmp = 0, n_bad = 0, cyc = 0;
   string       cur_req = "R1";
   int          mst   [NB];
   bit          mflag [NB];
   logic [31:0] mreg  [NB][11];
   bit          me_uns, me_inv, me_col;

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", cur_req, what, act, exp, cyc);
      end
   endtask

   // reference model: updated at each edge from the held inputs, compared 2 time units later
   always @(posedge clk) begin
      int  ent;
      bit  ld [NB];
      cyc++;
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin
            mst[b] = 0; mflag[b] = 1;
            for (int k = 0; k < 11; k++) mreg[b][k] = 0;
         end
         me_uns = 0; me_inv = 0; me_col = 0;
      end else begin
         me_uns = 0; me_inv = 0; me_col = 0; ent = 0;
         for (int b = 0; b < NB; b++) ld[b] = 0;
         if (start) begin
            if (mst[start_bank] != 0) me_col = 1;
            else begin
               case (int'(mreg[start_bank][0][5:0]))
                  1: ent = (mreg[start_bank][2] != 0) ? 1 : 2;
                  2: ent = 3;
                  3: ent = 4;
                  4: ent = 5;
                  default: if (mreg[start_bank][0][5:0] >= 5 && mreg[start_bank][0][5:0] <= 16) me_uns = 1;
                           else me_inv = 1;
               endcase
               if (ent != 0) ld[start_bank] = 1;
            end
         end
         if (wr_en) begin
            if (mst[wr_bank] != 0) me_col = 1;
            else if (wr_sel < 11) mreg[wr_bank][wr_sel] = wr_data;
         end
         for (int b = 0; b < NB; b++) begin
            if (ld[b]) begin
               mst[b] = ent;
               if (ent == 1) mflag[b] = 0;
            end else if (mst[b] != 0 && op_done[b]) mst[b] = 0;
            else if (mst[b] == 1 && xfer_done[b]) begin
               mst[b] = 2; mflag[b] = 1;
            end
         end
      end
      #2;
      for (int b = 0; b < NB; b++) begin
         chk($sformatf("state[%0d]", b), 32'(bank_state[b*3 +: 3]), 32'(mst[b]));
         chk($sformatf("busy[%0d]", b),  32'(bank_busy[b]), 32'(mst[b] != 0));
         chk($sformatf("flag[%0d]", b),  32'(xfer_flag[b]), 32'(mflag[b]));
      end
      chk("err_unsup", 32'(err_unsup), 32'(me_uns));
      chk("err_inval", 32'(err_inval), 32'(me_inv));
      chk("err_coll",  32'(err_coll),  32'(me_col));
      chk("rd_data", rd_data, (rd_sel < 11) ? mreg[rd_bank][rd_sel] : 32'h0);
   end

   task automatic wr(input int b, input int s, input logic [31:0] d);
      wr_en = 1; wr_bank = 2'(b); wr_sel = 4'(s); wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask
   task automatic go(input int b);
      start = 1; start_bank = 2'(b);
      @(negedge clk); start = 0;
   endtask
   task automatic done(input logic [3:0] m);
      op_done = m; @(negedge clk); op_done = 0;
   endtask
   task automatic xfer(input logic [3:0] m);
      xfer_done = m; @(negedge clk); xfer_done = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R1";                                   // reset values
      rst_n = 1; @(negedge clk);
      for (int k = 0; k < 11; k++) begin rd_sel = 4'(k); @(negedge clk); end

      cur_req = "R2";                                   // write map and read-back
      for (int k = 0; k < 11; k++) wr(0, k, 32'hA500_0000 + 32'(k) * 32'h111);
      for (int k = 0; k < 13; k++) begin rd_bank = 0; rd_sel = 4'(k); @(negedge clk); end
      wr(0, 12, 32'hDEAD_BEEF); rd_sel = 12; @(negedge clk);

      cur_req = "R6";                                   // program, zero buffer address
      wr(1, 0, 32'h1); wr(1, 2, 32'h0); go(1); @(negedge clk);
      cur_req = "R11"; done(4'b0010); @(negedge clk);

      cur_req = "R5";                                   // program with buffer, upper opcode bits set
      wr(2, 0, 32'hFFFF_FFC1); wr(2, 2, 32'h100); go(2);
      cur_req = "R3"; rd_bank = 2; rd_sel = 0; wr(2, 0, 32'h4); @(negedge clk);
      cur_req = "R12"; go(2); @(negedge clk);
      cur_req = "R10"; xfer(4'b0010); xfer(4'b0100); xfer(4'b0100); @(negedge clk);
      cur_req = "R11"; done(4'b0100);
      cur_req = "R3"; go(2); @(negedge clk);            // old opcode still in place
      cur_req = "R11"; xfer_done = 4'b0100; done(4'b0100); xfer_done = 0; @(negedge clk);

      cur_req = "R7";                                   // read, copyback, erase
      wr(3, 0, 32'h2); wr(0, 0, 32'h3); wr(1, 0, 32'h4);
      go(3); go(0); go(1); @(negedge clk);
      cur_req = "R11"; done(4'b1011); done(4'b0000);

      cur_req = "R8";                                   // defined but refused
      for (int op = 5; op <= 16; op++) begin wr(0, 0, 32'(op)); go(0); @(negedge clk); end
      cur_req = "R9";                                   // outside defined set
      for (int op = 0; op < 64; op++) begin
         if (op == 0 || op >= 17) begin wr(3, 0, 32'(op)); go(3); end
      end
      @(negedge clk);

      cur_req = "R4";                                   // mixed traffic
      for (int i = 0; i < 3000; i++) begin
         wr_en      = ($urandom_range(0, 3) == 0);
         wr_bank    = 2'($urandom);
         wr_sel     = 4'($urandom_range(0, 12));
         wr_data    = (wr_sel == 0) ? 32'($urandom_range(0, 20)) | ($urandom & 32'hFFFF_FFC0)
                                    : (($urandom_range(0, 1) == 0) ? 32'h0 : $urandom);
         start      = ($urandom_range(0, 2) == 0);
         start_bank = 2'($urandom);
         xfer_done  = 4'($urandom) & 4'($urandom);
         op_done    = 4'($urandom) & 4'($urandom) & 4'($urandom);
         rd_bank    = 2'($urandom);
         rd_sel     = 4'($urandom_range(0, 12));
         @(negedge clk);
      end
      wr_en = 0; start = 0; xfer_done = 0; op_done = 0;
      @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule